// File: doc/BRIEF.md
# Receive Signaling Processor

This block takes the robbed-bit or channel-associated signaling codes that a DS1/E1 receive path has already extracted, one code per time slot. It keeps them in a register file of 32 words, one word per slot. Each stored word has two parts. The low bits hold the code, packed to suit the slot's 16-, 4- or 2-state mode. The upper bits hold a field that names that mode. A host reads any word back through a registered read port.

An optional debounce accepts a code for a slot only when the same code arrives twice in a row for that slot. On the payload side, the block can force to 1 the robbed-bit position of voice slots. On the system side, it forwards each slot's code and forces the A bit to 1 for every slot whose handling group has lost alignment. Neither kind of forcing changes the stored words.

Top module: `rxsig_proc`

## Requirements
- R1: Bits 6:4 of a stored word name the mode. 000 is 16-state, 010 is 4-state and 110 is 2-state. On the `sigMode` input these modes are 00, 01 and 10.
- R2: In 16-state mode, bits 3:0 of the stored word hold D, C, B, A, which are `sigCode[3:0]` with A as bit 0.
- R3: In 4-state mode, bits 1:0 hold B, A and bits 3:2 are 0. In 2-state mode, bit 0 holds A and bits 3:1 are 0.
- R4: With `debounceEn` set, a strobed code is written to a slot only when the previous strobe for that same slot carried the same code.
- R5: With `debounceEn` clear, every strobed code is written on the clock edge that samples the strobe.
- R6: Reset clears the debounce history. With debounce enabled, the first code strobed for a slot after reset does not update that slot.
- R7: With `stompEn` set, a payload byte is forwarded one cycle later with bit 0 forced to 1 when `payVoice` is high and `payFrame` is 6 or 12.
- R8: Every other payload byte is forwarded one cycle later unchanged. This covers non-voice slots, other frames, and any byte while `stompEn` is clear.
- R9: `sysCode` gives the stored bits 3:0 of slot `sysSlot` one cycle later. Bit 0 (A) is forced to 1 when `hgFwdEn` is set and `hgAligned[sysSlot mod 4]` is 0.
- R10: Forcing the A bit on `sysCode` leaves the stored word unchanged, as seen on the host read port.
- R11: `rdData` returns the word for `rdAddr` one cycle after the address is presented. After reset every word reads 0.
- R12: While `hgFwdEn` is set, every strobed code is in 2-state mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigValid | input | 1 | Strobe that marks a new signaling code |
| sigSlot | input | 5 | Time slot of the strobed code |
| sigCode | input | 4 | Code with D, C, B, A at bits 3..0 |
| sigMode | input | 2 | State mode of the slot: 00 = 16, 01 = 4, 10 = 2 |
| debounceEn | input | 1 | Enables the two-match debounce |
| stompEn | input | 1 | Enables robbed-bit stomping |
| hgFwdEn | input | 1 | Enables forwarding of handling-group status |
| hgAligned | input | 4 | Alignment flag for each of the four handling groups |
| payValid | input | 1 | Payload byte valid |
| payData | input | 8 | Payload byte |
| payVoice | input | 1 | Current slot carries voice |
| payFrame | input | 4 | Frame number in the multiframe, 1..12 |
| payOutValid | output | 1 | Forwarded payload valid |
| payOutData | output | 8 | Forwarded payload byte |
| sysSlot | input | 5 | Slot selected for forwarding on the system side |
| sysCode | output | 4 | Forwarded code, with the A bit possibly forced |
| rdAddr | input | 5 | Host read address |
| rdData | output | 7 | Stored word for the host read |

## Verification
The assertions assume that a strobe never arrives in handling-group forwarding mode unless its code is in 2-state mode. They also assume that the payload inputs and the control bits hold defined values from the first edge after reset. The stimulus clears `hgFwdEn` while it writes 16- and 4-state codes, and sets it only after the last such write. Every input is driven to a known level from time zero. Inputs change only on the falling clock edge, so each strobe is sampled exactly once.

// File: rtl/rxsig_pkg.sv
package rxsig_pkg;
  parameter int NUM_SLOTS  = 32;
  parameter int CODE_W     = 4;
  parameter int WORD_W     = 7;
  parameter int NUM_GROUPS = 4;
  parameter int FRAME_W    = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int GRP_W     = $clog2(NUM_GROUPS);
  localparam logic [FRAME_W-1:0] ROB_FRAME_A = 4'd6;
  localparam logic [FRAME_W-1:0] ROB_FRAME_B = 4'd12;

  typedef enum logic [1:0] {
    MODE_16 = 2'b00,
    MODE_4  = 2'b01,
    MODE_2  = 2'b10
  } sigMode_e;

  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSlot;
    logic [WORD_W-1:0] wrWord;
  } ctrlStrobe_t;

  // Packs a code into the stored layout: mode tag in 6:4, code in 3:0.
  function automatic logic [WORD_W-1:0] packWord(input logic [1:0] mode,
                                                 input logic [CODE_W-1:0] code);
    case (mode)
      MODE_16: packWord = {3'b000, code};
      MODE_4:  packWord = {3'b010, 2'b00, code[1:0]};
      default: packWord = {3'b110, 3'b000, code[0]};
    endcase
  endfunction
endpackage

// File: rtl/rxsig_ctrl.sv
module rxsig_ctrl
  import rxsig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sigValid,
  input  logic [SLOT_W-1:0] sigSlot,
  input  logic [CODE_W-1:0] sigCode,
  input  logic [1:0]        sigMode,
  input  logic              debounceEn,
  output ctrlStrobe_t       strobe
);
  logic [CODE_W-1:0]    prevCode [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] prevVld;
  logic                 codeMatch;

  assign codeMatch = prevVld[sigSlot] && (prevCode[sigSlot] == sigCode);

  always_comb begin
    strobe.wrEn   = sigValid && (!debounceEn || codeMatch);
    strobe.wrSlot = sigSlot;
    strobe.wrWord = packWord(sigMode, sigCode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevVld <= '0;
    else if (sigValid) prevVld[sigSlot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (sigValid) prevCode[sigSlot] <= sigCode;
  end

  AST_FIRST_SEEN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && debounceEn && !prevVld[sigSlot]) |-> !strobe.wrEn); // R6
endmodule

// File: rtl/rxsig_datapath.sv
module rxsig_datapath
  import rxsig_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               stompEn,
  input  logic               hgFwdEn,
  input  logic [NUM_GROUPS-1:0] hgAligned,
  input  logic               payValid,
  input  logic [7:0]         payData,
  input  logic               payVoice,
  input  logic [FRAME_W-1:0] payFrame,
  output logic               payOutValid,
  output logic [7:0]         payOutData,
  input  logic [SLOT_W-1:0]  sysSlot,
  output logic [CODE_W-1:0]  sysCode,
  input  logic [SLOT_W-1:0]  rdAddr,
  output logic [WORD_W-1:0]  rdData
);
  logic [WORD_W-1:0] regFile [NUM_SLOTS];
  logic              robbedPos;
  logic [GRP_W-1:0]  sysGroup;
  logic [CODE_W-1:0] sysNext;

  assign robbedPos = stompEn && payVoice &&
                     (payFrame == ROB_FRAME_A || payFrame == ROB_FRAME_B);
  assign sysGroup  = sysSlot[GRP_W-1:0];

  always_comb begin
    sysNext = regFile[sysSlot][CODE_W-1:0];
    if (hgFwdEn && !hgAligned[sysGroup]) sysNext[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) regFile[i] <= '0;
    end else if (strobe.wrEn) begin
      regFile[strobe.wrSlot] <= strobe.wrWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData      <= '0;
      sysCode     <= '0;
      payOutValid <= 1'b0;
      payOutData  <= '0;
    end else begin
      rdData      <= regFile[rdAddr];
      sysCode     <= sysNext;
      payOutValid <= payValid;
      payOutData  <= {payData[7:1], payData[0] | robbedPos};
    end
  end

  AST_MODE_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rdData[6:4] inside {3'b000, 3'b010, 3'b110}); // R1
  AST_FOUR_STATE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[6:4] == 3'b010) |-> (rdData[3:2] == 2'b00)); // R3
  AST_TWO_STATE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[6:4] == 3'b110) |-> (rdData[3:1] == 3'b000)); // R3
  AST_STOMP_SET: assert property (@(posedge clk) disable iff (!rstN)
    (payValid && stompEn && payVoice && (payFrame == 4'd6 || payFrame == 4'd12))
      |=> (payOutValid && payOutData[0])); // R7
  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rstN)
    payValid |=> (payOutData[7:1] == $past(payData[7:1]))); // R8
  AST_GROUP_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (hgFwdEn && !hgAligned[sysSlot[GRP_W-1:0]]) |=> sysCode[0]); // R9
endmodule

// File: rtl/rxsig_proc.sv
module rxsig_proc
  import rxsig_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sigValid,
  input  logic [4:0]   sigSlot,
  input  logic [3:0]   sigCode,
  input  logic [1:0]   sigMode,
  input  logic         debounceEn,
  input  logic         stompEn,
  input  logic         hgFwdEn,
  input  logic [3:0]   hgAligned,
  input  logic         payValid,
  input  logic [7:0]   payData,
  input  logic         payVoice,
  input  logic [3:0]   payFrame,
  output logic         payOutValid,
  output logic [7:0]   payOutData,
  input  logic [4:0]   sysSlot,
  output logic [3:0]   sysCode,
  input  logic [4:0]   rdAddr,
  output logic [6:0]   rdData
);
  ctrlStrobe_t strobe;

  rxsig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sigValid(sigValid), .sigSlot(sigSlot),
    .sigCode(sigCode), .sigMode(sigMode), .debounceEn(debounceEn),
    .strobe(strobe)
  );

  rxsig_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stompEn(stompEn),
    .hgFwdEn(hgFwdEn), .hgAligned(hgAligned), .payValid(payValid),
    .payData(payData), .payVoice(payVoice), .payFrame(payFrame),
    .payOutValid(payOutValid), .payOutData(payOutData),
    .sysSlot(sysSlot), .sysCode(sysCode), .rdAddr(rdAddr), .rdData(rdData)
  );

  AST_HG_TWO_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && hgFwdEn) |-> (sigMode == MODE_2)); // R12
endmodule

// File: tb/rxsig_proc_tb.sv
`timescale 1ns/1ps
module rxsig_proc_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigValid = 1'b0;
  logic [4:0] sigSlot = '0;
  logic [3:0] sigCode = '0;
  logic [1:0] sigMode = '0;
  logic debounceEn = 1'b0, stompEn = 1'b0, hgFwdEn = 1'b0;
  logic [3:0] hgAligned = 4'hF;
  logic payValid = 1'b0;
  logic [7:0] payData = '0;
  logic payVoice = 1'b0;
  logic [3:0] payFrame = 4'd1;
  logic payOutValid;
  logic [7:0] payOutData;
  logic [4:0] sysSlot = '0;
  logic [3:0] sysCode;
  logic [4:0] rdAddr = '0;
  logic [6:0] rdData;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  rxsig_proc u_dut (.*);

  // {slot, mode, code, expected word}
  localparam int NVEC = 6;
  localparam logic [17:0] VECS [NVEC] = '{
    {5'd0,  2'b00, 4'hB, 7'h0B},
    {5'd5,  2'b01, 4'hF, 7'h23},
    {5'd9,  2'b10, 4'hF, 7'h61},
    {5'd31, 2'b00, 4'h6, 7'h06},
    {5'd17, 2'b01, 4'h6, 7'h22},
    {5'd22, 2'b10, 4'hE, 7'h60}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putSig(input logic [4:0] s, input logic [1:0] m, input logic [3:0] c);
    @(negedge clk);
    sigSlot = s; sigMode = m; sigCode = c; sigValid = 1'b1;
    @(negedge clk);
    sigValid = 1'b0;
  endtask

  task automatic readWord(input logic [4:0] a, output logic [6:0] w);
    @(negedge clk);
    rdAddr = a;
    @(negedge clk);
    w = rdData;
  endtask

  task automatic sendPay(input logic [7:0] d, input logic v, input logic [3:0] f,
                         output logic [7:0] o);
    @(negedge clk);
    payValid = 1'b1; payData = d; payVoice = v; payFrame = f;
    @(negedge clk);
    o = payOutData;
    payValid = 1'b0;
  endtask

  task automatic readSys(input logic [4:0] s, output logic [3:0] c);
    @(negedge clk);
    sysSlot = s;
    @(negedge clk);
    c = sysCode;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [6:0] w;
    logic [7:0] o;
    logic [3:0] c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset contents and read latency
    readWord(5'd0, w);  check("R11 reset slot0", w, 7'h00);
    readWord(5'd31, w); check("R11 reset slot31", w, 7'h00);

    // R1 R2 R3 R5: table walk with debounce off
    for (int i = 0; i < NVEC; i++) begin
      putSig(VECS[i][17:13], VECS[i][12:11], VECS[i][10:7]);
      readWord(VECS[i][17:13], w);
      check("R1/R2/R3/R5 table", w, VECS[i][6:0]);
    end

    // R6 R4: debounce, fresh history for slot 3 since reset
    debounceEn = 1'b1;
    putSig(5'd3, 2'b00, 4'h5);
    readWord(5'd3, w); check("R6 first code held", w, 7'h00);
    putSig(5'd3, 2'b00, 4'h5);
    readWord(5'd3, w); check("R4 second match", w, 7'h05);
    putSig(5'd3, 2'b00, 4'h9);
    readWord(5'd3, w); check("R4 single new code", w, 7'h05);
    putSig(5'd3, 2'b00, 4'h5);
    putSig(5'd3, 2'b00, 4'h9);
    readWord(5'd3, w); check("R4 alternating", w, 7'h05);
    putSig(5'd3, 2'b00, 4'h9);
    readWord(5'd3, w); check("R4 repeat accepted", w, 7'h09);
    debounceEn = 1'b0;
    putSig(5'd3, 2'b00, 4'h2);
    readWord(5'd3, w); check("R5 immediate", w, 7'h02);

    // R7 R8: stomping
    stompEn = 1'b1;
    sendPay(8'h40, 1'b1, 4'd6, o);  check("R7 frame6 voice", o, 8'h41);
    sendPay(8'hFE, 1'b1, 4'd12, o); check("R7 frame12 voice", o, 8'hFF);
    sendPay(8'h40, 1'b1, 4'd7, o);  check("R8 frame7", o, 8'h40);
    sendPay(8'h40, 1'b0, 4'd12, o); check("R8 data slot", o, 8'h40);
    stompEn = 1'b0;
    sendPay(8'h40, 1'b1, 4'd6, o);  check("R8 stomp off", o, 8'h40);

    // R9 R10 R12: handling groups, 2-state writes only while enabled
    putSig(5'd2, 2'b10, 4'h0);
    hgFwdEn = 1'b1;
    hgAligned = 4'b1011;
    readSys(5'd2, c);  check("R9 group2 forced slot2", c, 4'h1);
    readSys(5'd22, c); check("R9 group2 forced slot22", c, 4'h1);
    readSys(5'd3, c);  check("R9 group3 aligned", c, 4'h2);
    readSys(5'd0, c);  check("R9 group0 aligned", c, 4'hB);
    readWord(5'd2, w); check("R10 stored unchanged", w, 7'h60);
    putSig(5'd6, 2'b10, 4'h0);
    readWord(5'd6, w); check("R12 two-state write", w, 7'h60);
    hgAligned = 4'hF;
    readSys(5'd2, c);  check("R9 realigned", c, 4'h0);
    hgFwdEn = 1'b0;
    hgAligned = 4'h0;
    readSys(5'd6, c);  check("R9 forwarding off", c, 4'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule